// File: doc/BRIEF.md
# Camera Sync Interrupt Status Unit

This unit gathers the event flags of a parallel camera capture port and turns them into one interrupt line. It watches the horizontal and vertical sync inputs, and each input has its own programmable active level. It also takes these inputs:

- pulses for a sync-code ordering error and for a data buffer overrun;
- end-of-line and end-of-frame timing pulses;
- the crop settings, used to decide when a captured window has finished.

Each event latches a sticky bit in a raw status word. Software reads that word, chooses which bits can raise the interrupt through an enable word, and removes bits by writing ones to a clear word.

Two synchronization modes are supported. In hardware mode the sync lines come straight from pins. In embedded mode they are produced upstream from codes in the data stream. In embedded mode, sync edges count only while capture is enabled, and the ordering-error event is honoured only in that mode.

The register bus uses one word address and a write strobe, with combinational read data. The masked status word is also driven as a port.

Top module: `camSyncIrq`

## Requirements
- R1: After reset, the raw status, the enable word, the masked status and the interrupt output are all zero. Reads of word address 0 return the raw status with the line flag at bit 4, vsync at bit 3, sync error at bit 2, overrun at bit 1 and frame done at bit 0. Bits 31 to 5 read as zero.
- R2: The line flag sets at the clock edge where the horizontal sync input is first seen at its active level after being inactive. The active level is high when `hsActHigh` is 1 and low when it is 0. Holding the active level does not set the flag again after it is cleared.
- R3: The vsync flag sets at the clock edge where the vertical sync input is first seen active after being inactive, with the active level chosen by `vsActHigh` in the same way.
- R4: When `embeddedMode` is 1, the line and vsync flags are set by sync edges only while `captureEn` is 1. When `embeddedMode` is 0, `captureEn` has no effect on them.
- R5: A cycle with `syncErrPulse` high sets the sync error flag only when `embeddedMode` is 1. Otherwise the pulse is ignored.
- R6: A cycle with `overrunPulse` high sets the overrun flag.
- R7: With `cropEn` 0, a `frameEndPulse` sets the frame flag. With `cropEn` 1, lines are numbered from 0 by counting `lineEndPulse` cycles since the last frame end, and the frame flag sets on the `lineEndPulse` of line number `cropLastLine`. It does not set again at the following frame end.
- R8: With `cropEn` 1, if the frame ends before line `cropLastLine` has ended, the frame flag sets on the `frameEndPulse`. This is the empty-window case.
- R9: A bus write to word address 2 clears each raw flag whose data bit is 1. Data bits at 0 leave their flags unchanged. When a set event and a clear hit the same flag in the same cycle, the flag stays 1. Word address 2 reads as zero.
- R10: A bus write to word address 1 loads the low five data bits into the enable word, which reads back at address 1. `maskedStatus` equals the raw status ANDed with the enable word. The raw status read at address 0 is not masked.
- R11: `irqOut` is registered. It equals the OR of `maskedStatus` as it stood one clock earlier, so it rises one cycle after an enabled flag sets and falls one cycle after the last enabled flag is cleared or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncIn | input | 1 | Horizontal sync level |
| vsyncIn | input | 1 | Vertical sync level |
| hsActHigh | input | 1 | 1: horizontal sync is active high |
| vsActHigh | input | 1 | 1: vertical sync is active high |
| embeddedMode | input | 1 | 1: embedded synchronization mode |
| captureEn | input | 1 | Capture enable |
| syncErrPulse | input | 1 | Sync code ordering error, one cycle |
| overrunPulse | input | 1 | Data buffer overrun, one cycle |
| lineEndPulse | input | 1 | End of a line, one cycle |
| frameEndPulse | input | 1 | End of a frame, one cycle |
| cropEn | input | 1 | Cropping enabled |
| cropLastLine | input | LINE_W | Number of the last line in the crop window |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register word address |
| busWData | input | DATA_W | Register write data |
| busRData | output | DATA_W | Register read data, combinational on busAddr |
| maskedStatus | output | 5 | Raw status ANDed with the enable word |
| irqOut | output | 1 | Interrupt request |

## Verification
All flags register at the clock edge that samples their event, so a raw flag and the masked status can be read at the falling edge that follows that edge. The interrupt output is due one edge later. The bench drives every input at a falling edge. It advances exactly one rising edge per event, reads the combinational read port shortly after the next falling edge, and checks `irqOut` both before and after its extra edge, so that an early or late interrupt is reported. Crop sweeps place the last crop line at every line of a four-line frame and beyond it. The bench resets the line count with a frame end before each sweep point and clears the flag between checks, so each check shows exactly one set.

// File: rtl/camSyncPkg.sv
package camSyncPkg;
  localparam int NUM_EVT   = 5;
  localparam int EVT_FRAME = 0;
  localparam int EVT_OVR   = 1;
  localparam int EVT_ERR   = 2;
  localparam int EVT_VSYNC = 3;
  localparam int EVT_LINE  = 4;

  typedef enum logic [1:0] {
    REG_RAW  = 2'd0,
    REG_ENA  = 2'd1,
    REG_CLR  = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [NUM_EVT-1:0] setVec;
    logic               enaWr;
    logic               clrWr;
  } ctrlStrobe_t;
endpackage

// File: rtl/camSyncEdge.sv
module camSyncEdge (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic actHigh,
  output logic riseOut
);
  logic actLvl;
  logic prevLvl;

  // normalise to "1 = active" regardless of programmed polarity
  assign actLvl = pinIn ~^ actHigh;

  // reset to active so a line already active at reset is not an edge
  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b1;
    else       prevLvl <= actLvl;
  end

  assign riseOut = actLvl & ~prevLvl;
endmodule

// File: rtl/camSyncCtrl.sv
module camSyncCtrl
  import camSyncPkg::*;
#(
  parameter int LINE_W = 12,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic              hsActHigh,
  input  logic              vsActHigh,
  input  logic              embeddedMode,
  input  logic              captureEn,
  input  logic              syncErrPulse,
  input  logic              overrunPulse,
  input  logic              lineEndPulse,
  input  logic              frameEndPulse,
  input  logic              cropEn,
  input  logic [LINE_W-1:0] cropLastLine,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  localparam int NUM_SYNC = 2;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [NUM_SYNC-1:0] syncPin;
  logic [NUM_SYNC-1:0] syncPol;
  logic [NUM_SYNC-1:0] syncRise;
  logic                syncGate;
  logic [LINE_W-1:0]   lineCnt;
  logic                cropDone;
  logic                cropHit;
  logic                frameSet;

  assign syncPin = {vsyncIn, hsyncIn};
  assign syncPol = {vsActHigh, hsActHigh};

  for (genvar gi = 0; gi < NUM_SYNC; gi++) begin : gSync
    camSyncEdge uEdge (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (syncPin[gi]),
      .actHigh(syncPol[gi]),
      .riseOut(syncRise[gi])
    );
  end

  // in embedded mode sync edges only count while capturing
  assign syncGate = ~embeddedMode | captureEn;

  // crop window end tracking
  assign cropHit  = cropEn & lineEndPulse & ~cropDone & (lineCnt == cropLastLine);
  assign frameSet = cropHit | (frameEndPulse & (~cropEn | ~cropDone));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt  <= '0;
      cropDone <= 1'b0;
    end else if (frameEndPulse) begin
      lineCnt  <= '0;
      cropDone <= 1'b0;
    end else begin
      if (lineEndPulse && lineCnt != LINE_MAX) lineCnt <= lineCnt + 1'b1;
      if (cropHit) cropDone <= 1'b1;
    end
  end

  always_comb begin
    strobe                  = '0;
    strobe.setVec[EVT_LINE]  = syncRise[0] & syncGate;
    strobe.setVec[EVT_VSYNC] = syncRise[1] & syncGate;
    strobe.setVec[EVT_ERR]   = syncErrPulse & embeddedMode;
    strobe.setVec[EVT_OVR]   = overrunPulse;
    strobe.setVec[EVT_FRAME] = frameSet;
    strobe.enaWr            = busWrEn && (busAddr == ADDR_W'(REG_ENA));
    strobe.clrWr            = busWrEn && (busAddr == ADDR_W'(REG_CLR));
  end
endmodule

// File: rtl/camSyncDatapath.sv
module camSyncDatapath
  import camSyncPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWData,
  output logic [DATA_W-1:0]  busRData,
  output logic [NUM_EVT-1:0] rawStatus,
  output logic [NUM_EVT-1:0] maskedStatus,
  output logic               irqOut
);
  logic [NUM_EVT-1:0] enaReg;
  logic [NUM_EVT-1:0] clrBits;
  logic               unusedHiBits;

  assign clrBits      = strobe.clrWr ? busWData[NUM_EVT-1:0] : '0;
  assign unusedHiBits = ^busWData[DATA_W-1:NUM_EVT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawStatus <= '0;
      enaReg    <= '0;
      irqOut    <= 1'b0;
    end else begin
      // set takes priority over a simultaneous clear
      rawStatus <= (rawStatus & ~clrBits) | strobe.setVec;
      if (strobe.enaWr) enaReg <= busWData[NUM_EVT-1:0];
      irqOut    <= |maskedStatus;
    end
  end

  assign maskedStatus = rawStatus & enaReg;

  always_comb begin
    busRData = '0;
    case (busAddr)
      ADDR_W'(REG_RAW): busRData[NUM_EVT-1:0] = rawStatus;
      ADDR_W'(REG_ENA): busRData[NUM_EVT-1:0] = enaReg;
      default:          busRData = '0;
    endcase
  end
endmodule

// File: rtl/camSyncIrq.sv
module camSyncIrq
  import camSyncPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int LINE_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  input  logic               hsActHigh,
  input  logic               vsActHigh,
  input  logic               embeddedMode,
  input  logic               captureEn,
  input  logic               syncErrPulse,
  input  logic               overrunPulse,
  input  logic               lineEndPulse,
  input  logic               frameEndPulse,
  input  logic               cropEn,
  input  logic [LINE_W-1:0]  cropLastLine,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWData,
  output logic [DATA_W-1:0]  busRData,
  output logic [NUM_EVT-1:0] maskedStatus,
  output logic               irqOut
);
  ctrlStrobe_t        strobe;
  logic [NUM_EVT-1:0] rawStatus;

  camSyncCtrl #(.LINE_W(LINE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .hsyncIn      (hsyncIn),
    .vsyncIn      (vsyncIn),
    .hsActHigh    (hsActHigh),
    .vsActHigh    (vsActHigh),
    .embeddedMode (embeddedMode),
    .captureEn    (captureEn),
    .syncErrPulse (syncErrPulse),
    .overrunPulse (overrunPulse),
    .lineEndPulse (lineEndPulse),
    .frameEndPulse(frameEndPulse),
    .cropEn       (cropEn),
    .cropLastLine (cropLastLine),
    .busWrEn      (busWrEn),
    .busAddr      (busAddr),
    .strobe       (strobe)
  );

  camSyncDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busAddr     (busAddr),
    .busWData    (busWData),
    .busRData    (busRData),
    .rawStatus   (rawStatus),
    .maskedStatus(maskedStatus),
    .irqOut      (irqOut)
  );
endmodule

// File: rtl/camSyncChk.sv
module camSyncChk
  import camSyncPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               embeddedMode,
  input logic               syncErrPulse,
  input logic               overrunPulse,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWData,
  input logic [DATA_W-1:0]  busRData,
  input logic [NUM_EVT-1:0] rawStatus,
  input logic [NUM_EVT-1:0] maskedStatus,
  input logic               irqOut
);
  // R1
  raw_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(REG_RAW)) |-> (busRData[DATA_W-1:NUM_EVT] == '0));

  // R5
  err_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStatus[EVT_ERR]) |-> $past(embeddedMode && syncErrPulse));

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |=> rawStatus[EVT_OVR]);

  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(REG_CLR) && busWData[EVT_OVR] && !overrunPulse)
      |=> !rawStatus[EVT_OVR]);

  // R10
  mask_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStatus & ~rawStatus) == '0);

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|maskedStatus) |=> irqOut);

  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|maskedStatus) |=> !irqOut);
endmodule

bind camSyncIrq camSyncChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .embeddedMode(embeddedMode),
  .syncErrPulse(syncErrPulse),
  .overrunPulse(overrunPulse),
  .busWrEn     (busWrEn),
  .busAddr     (busAddr),
  .busWData    (busWData),
  .busRData    (busRData),
  .rawStatus   (rawStatus),
  .maskedStatus(maskedStatus),
  .irqOut      (irqOut)
);

// File: tb/tb_camSyncIrq.sv
module tb_camSyncIrq;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int LINE_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hsyncIn = 1'b0, vsyncIn = 1'b0;
  logic              hsActHigh = 1'b1, vsActHigh = 1'b1;
  logic              embeddedMode = 1'b0, captureEn = 1'b0;
  logic              syncErrPulse = 1'b0, overrunPulse = 1'b0;
  logic              lineEndPulse = 1'b0, frameEndPulse = 1'b0;
  logic              cropEn = 1'b0;
  logic [LINE_W-1:0] cropLastLine = '0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWData = '0;
  logic [DATA_W-1:0] busRData;
  logic [4:0]        maskedStatus;
  logic              irqOut;

  int nVec = 0;
  int nErr = 0;

  always #5 clk = ~clk;

  camSyncIrq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) dut (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRData;
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busAddr  = a;
    busWData = d;
    busWrEn  = 1'b1;
    step();
    busWrEn  = 1'b0;
    busWData = '0;
  endtask

  task automatic clearAll();
    writeReg(2'd2, 32'h1f);
  endtask

  logic [31:0] rd;

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(2'd0, rd); check("R1 raw reset", rd, 0);
    readReg(2'd1, rd); check("R1 enable reset", rd, 0);
    check("R1 masked reset", 32'(maskedStatus), 0);
    check("R1 irq reset", 32'(irqOut), 0);

    // R2 R3 R4 polarity x mode x capture sweep
    for (int pol = 0; pol < 2; pol++)
      for (int emb = 0; emb < 2; emb++)
        for (int cap = 0; cap < 2; cap++) begin
          logic expSet;
          expSet = (emb == 0) || (cap == 1);
          hsActHigh = pol[0]; vsActHigh = pol[0];
          hsyncIn = ~pol[0];  vsyncIn = ~pol[0];
          embeddedMode = emb[0]; captureEn = cap[0];
          step(); step();
          clearAll();
          hsyncIn = pol[0];
          step();
          readReg(2'd0, rd); check("R2 R4 line edge", rd, 32'(expSet) << 4);
          clearAll();
          step();
          readReg(2'd0, rd); check("R2 held level no reset", rd, 0);
          hsyncIn = ~pol[0];
          step();
          vsyncIn = pol[0];
          step();
          readReg(2'd0, rd); check("R3 R4 vsync edge", rd, 32'(expSet) << 3);
          vsyncIn = ~pol[0];
          step();
          clearAll();
        end

    // R5 sync error gating
    embeddedMode = 1'b0; syncErrPulse = 1'b1; step(); syncErrPulse = 1'b0;
    readReg(2'd0, rd); check("R5 error ignored in hw mode", rd, 0);
    embeddedMode = 1'b1; syncErrPulse = 1'b1; step(); syncErrPulse = 1'b0;
    readReg(2'd0, rd); check("R5 error in embedded mode", rd, 32'h4);
    // R6 overrun
    overrunPulse = 1'b1; step(); overrunPulse = 1'b0;
    readReg(2'd0, rd); check("R6 overrun set", rd, 32'h6);

    // R9 clear behaviour
    writeReg(2'd2, 32'h0);
    readReg(2'd0, rd); check("R9 zero write no effect", rd, 32'h6);
    writeReg(2'd2, 32'hffff_ffe4);
    readReg(2'd0, rd); check("R9 selective clear", rd, 32'h2);
    overrunPulse = 1'b1;
    writeReg(2'd2, 32'h2);
    overrunPulse = 1'b0;
    readReg(2'd0, rd); check("R9 set wins over clear", rd, 32'h2);
    clearAll();
    readReg(2'd0, rd); check("R9 clear all", rd, 0);
    readReg(2'd2, rd); check("R9 clear word reads zero", rd, 0);

    // set every flag at once
    hsActHigh = 1'b1; vsActHigh = 1'b1; hsyncIn = 1'b0; vsyncIn = 1'b0;
    embeddedMode = 1'b1; captureEn = 1'b1; cropEn = 1'b0;
    step();
    hsyncIn = 1'b1; vsyncIn = 1'b1; syncErrPulse = 1'b1;
    overrunPulse = 1'b1; frameEndPulse = 1'b1;
    step();
    hsyncIn = 1'b0; vsyncIn = 1'b0; syncErrPulse = 1'b0;
    overrunPulse = 1'b0; frameEndPulse = 1'b0;
    readReg(2'd0, rd); check("R1 all flags set", rd, 32'h1f);

    // R10 R11 enable sweep
    for (int en = 0; en < 32; en++) begin
      logic prevIrq;
      prevIrq = (en != 0) && ((en - 1) != 0);
      writeReg(2'd1, 32'(en));
      readReg(2'd1, rd); check("R10 enable readback", rd, 32'(en));
      readReg(2'd0, rd); check("R10 raw unmasked", rd, 32'h1f);
      check("R10 masked status", 32'(maskedStatus), 32'(en));
      check("R11 irq not yet updated", 32'(irqOut), 32'(prevIrq));
      step();
      check("R11 irq follows mask", 32'(irqOut), 32'(en != 0));
    end

    // R11 rise and fall timing
    writeReg(2'd1, 32'h2);
    clearAll();
    step();
    check("R11 irq idle", 32'(irqOut), 0);
    overrunPulse = 1'b1; step(); overrunPulse = 1'b0;
    check("R11 masked after set", 32'(maskedStatus), 32'h2);
    check("R11 irq one cycle late", 32'(irqOut), 0);
    step();
    check("R11 irq rises", 32'(irqOut), 1);
    clearAll();
    check("R11 irq still high at clear", 32'(irqOut), 1);
    step();
    check("R11 irq falls", 32'(irqOut), 0);

    // R7 no crop: frame end sets frame flag
    cropEn = 1'b0;
    frameEndPulse = 1'b1; step(); frameEndPulse = 1'b0;
    readReg(2'd0, rd); check("R7 frame end no crop", rd, 32'h1);
    clearAll();

    // R7 R8 crop sweep over a four-line frame
    cropEn = 1'b1;
    for (int last = 0; last < 7; last++) begin
      cropLastLine = LINE_W'(last);
      frameEndPulse = 1'b1; step(); frameEndPulse = 1'b0;
      clearAll();
      for (int ln = 0; ln < 4; ln++) begin
        lineEndPulse = 1'b1; step(); lineEndPulse = 1'b0;
        readReg(2'd0, rd);
        check("R7 crop last line", rd, 32'(ln == last));
        clearAll();
      end
      frameEndPulse = 1'b1; step(); frameEndPulse = 1'b0;
      readReg(2'd0, rd);
      check("R7 R8 frame end after crop", rd, 32'(last > 3));
      clearAll();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule